// File: doc/BRIEF.md
# Ramped Active-Video Window

This block decides, pixel by pixel, whether picture data is shown or blanked on a video line, and it softens every change between the two. A position counter restarts at each line-start strobe and counts only the cycles on which the pixel enable is high. The window opens at a programmable open position and closes at a programmable close position. Instead of switching hard at those points, the data passes through a gain stage that steps between zero and unity in equal quarter steps, one step per pixel.

An optional external gate can be merged with the internal window when a select bit is set. While that gate is low the picture is held blanked. Edges caused by the gate go through the same ramp as edges of the internal window. When a ramp-down starts, the last pixel that was inside the window is frozen and faded out. When a window closes before its ramp-up has finished, the gain turns back from the level it has reached. The effective window of each pixel is also given as a registered status bit, aligned with the scaled data.

Top module: `vid_window_ramp`

## Requirements
- R1: During reset and after it, until the first enabled pixel, `pix_out` is 0 and `win_stat` is 0.
- R2: A pixel presented with `line_start` high has position 0, and each later enabled pixel is one position higher. `line_start` on a cycle with `pix_en` low makes the next enabled pixel position 0. Cycles with `pix_en` low do not advance the position.
- R3: With `ext_sel` low, a pixel at position p is inside the window when `open_cnt` <= p < `close_cnt`, and `ext_win` has no effect.
- R4: The gain level runs from 0 to 4, and the output is floor(sample x level / 4). An inside pixel raises the level by one step (saturating at 4) and is itself the sample. The first inside pixel therefore leaves at 1/4 gain, the next ones at 2/4 and 3/4, and later ones unchanged.
- R5: An outside pixel lowers the level by one step (floor 0). Its sample is the last pixel that was inside the window, so a full window fades through 3/4, 2/4 and 1/4 of that pixel and then outputs 0. Outside pixel data has no effect.
- R6: If the window closes while the level is still below 4, the fall starts from the current level and does not jump.
- R7: With `ext_sel` high and `ext_win` low, a pixel counts as outside whatever its position. With `ext_sel` high and `ext_win` high, the internal window decides.
- R8: Window edges caused by `ext_win` go through the same one-step-per-pixel ramp as internal edges, including reversal from a partial level.
- R9: `win_stat` is the registered effective window of the most recent enabled pixel, and it changes on the same clock as the matching `pix_out`.
- R10: On cycles with `pix_en` low, `pix_out`, `win_stat` and the gain level keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Marks a cycle that carries a pixel |
| line_start | input | 1 | Start-of-line strobe |
| open_cnt | input | POS_W | First position inside the window |
| close_cnt | input | POS_W | First position after the window |
| ext_sel | input | 1 | Merges the external gate with the window |
| ext_win | input | 1 | External gate, low forces blanking when selected |
| pix_in | input | DATA_W | Pixel sample |
| pix_out | output | DATA_W | Pixel scaled by the ramp gain, one cycle later |
| win_stat | output | 1 | Registered effective window |

## Verification
The hardest case to reach is a window that closes partway through its ramp-up. The fall must then start from the partial level and fade a frozen pixel, not the live one. The sweep reaches this case with windows only one, two or three pixels wide. It does the same with short external-gate pulses in the middle of an open window. Idle cycles are placed inside those ramps, and a line restarts in the middle of a window, so the hold and restart rules are tested while the gain is between its end values.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  typedef enum logic [1:0] {
    PH_DARK = 2'd0,
    PH_RISE = 2'd1,
    PH_OPEN = 2'd2,
    PH_FALL = 2'd3
  } ramp_phase_e;
endpackage

// File: rtl/vwr_pos_counter.sv
module vwr_pos_counter #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             line_start,
  output logic [POS_W-1:0] cur_pos,
  output logic [POS_W-1:0] pos_q
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  function automatic logic [POS_W-1:0] advance(input logic [POS_W-1:0] p);
    return (p == POS_MAX) ? p : p + 1'b1;
  endfunction

  assign cur_pos = line_start ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pix_en) begin
      pos_q <= advance(cur_pos);
    end else if (line_start) begin
      pos_q <= '0;
    end
  end
endmodule

// File: rtl/vwr_window_gate.sv
module vwr_window_gate #(
  parameter int POS_W = 11
) (
  input  logic [POS_W-1:0] cur_pos,
  input  logic [POS_W-1:0] open_cnt,
  input  logic [POS_W-1:0] close_cnt,
  input  logic             ext_sel,
  input  logic             ext_win,
  output logic             int_win,
  output logic             eff_win
);
  function automatic logic inside_span(input logic [POS_W-1:0] p,
                                       input logic [POS_W-1:0] lo,
                                       input logic [POS_W-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  assign int_win = inside_span(cur_pos, open_cnt, close_cnt);
  assign eff_win = int_win && (!ext_sel || ext_win);
endmodule

// File: rtl/vwr_ramp_gain.sv
module vwr_ramp_gain
  import vwr_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int RAMP_LEN = 4,
  localparam int SHIFT   = $clog2(RAMP_LEN),
  localparam int LVL_W   = SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              eff_win,
  input  logic [DATA_W-1:0] pix_in,
  output logic [DATA_W-1:0] pix_out,
  output logic              win_stat,
  output logic [LVL_W-1:0]  level,
  output ramp_phase_e       phase
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(RAMP_LEN);
  localparam int PROD_W = DATA_W + LVL_W;

  function automatic logic [LVL_W-1:0] step_level(input logic [LVL_W-1:0] l,
                                                  input logic up);
    if (up) return (l == LVL_MAX) ? l : l + 1'b1;
    return (l == '0) ? l : l - 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] scale(input logic [DATA_W-1:0] s,
                                              input logic [LVL_W-1:0] g);
    logic [PROD_W-1:0] prod;
    prod = {{LVL_W{1'b0}}, s} * {{DATA_W{1'b0}}, g};
    return prod[SHIFT +: DATA_W];
  endfunction

  function automatic ramp_phase_e classify(input logic [LVL_W-1:0] l,
                                           input logic up);
    if (l == '0) return PH_DARK;
    if (l == LVL_MAX) return PH_OPEN;
    return up ? PH_RISE : PH_FALL;
  endfunction

  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] sample;
  logic [LVL_W-1:0]  level_nxt;

  assign level_nxt = step_level(level, eff_win);
  assign sample    = eff_win ? pix_in : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level    <= '0;
      held_q   <= '0;
      pix_out  <= '0;
      win_stat <= 1'b0;
      phase    <= PH_DARK;
    end else if (pix_en) begin
      level    <= level_nxt;
      pix_out  <= scale(sample, level_nxt);
      win_stat <= eff_win;
      phase    <= classify(level_nxt, eff_win);
      if (eff_win) held_q <= pix_in;
    end
  end
endmodule

// File: rtl/vid_window_ramp.sv
module vid_window_ramp
  import vwr_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int POS_W    = 11,
  parameter int RAMP_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              line_start,
  input  logic [POS_W-1:0]  open_cnt,
  input  logic [POS_W-1:0]  close_cnt,
  input  logic              ext_sel,
  input  logic              ext_win,
  input  logic [DATA_W-1:0] pix_in,
  output logic [DATA_W-1:0] pix_out,
  output logic              win_stat
);
  localparam int LVL_W = $clog2(RAMP_LEN) + 1;

  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] pos_q;
  logic             int_win;
  logic             eff_win;
  logic [LVL_W-1:0] level;
  ramp_phase_e      phase;

  vwr_pos_counter #(.POS_W(POS_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .line_start (line_start),
    .cur_pos    (cur_pos),
    .pos_q      (pos_q)
  );

  vwr_window_gate #(.POS_W(POS_W)) u_gate (
    .cur_pos   (cur_pos),
    .open_cnt  (open_cnt),
    .close_cnt (close_cnt),
    .ext_sel   (ext_sel),
    .ext_win   (ext_win),
    .int_win   (int_win),
    .eff_win   (eff_win)
  );

  vwr_ramp_gain #(.DATA_W(DATA_W), .RAMP_LEN(RAMP_LEN)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_en   (pix_en),
    .eff_win  (eff_win),
    .pix_in   (pix_in),
    .pix_out  (pix_out),
    .win_stat (win_stat),
    .level    (level),
    .phase    (phase)
  );
endmodule

// File: rtl/vwr_checker.sv
module vwr_checker
  import vwr_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int POS_W    = 11,
  parameter int RAMP_LEN = 4,
  localparam int LVL_W   = $clog2(RAMP_LEN) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic              line_start,
  input logic              ext_sel,
  input logic              ext_win,
  input logic              eff_win,
  input logic [DATA_W-1:0] pix_in,
  input logic [DATA_W-1:0] pix_out,
  input logic              win_stat,
  input logic [POS_W-1:0]  pos_q,
  input logic [LVL_W-1:0]  level,
  input ramp_phase_e       phase
);
  assert_level_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (int'(level) - int'($past(level)) <= 1) &&
               (int'($past(level)) - int'(level) <= 1));

  assert_level_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= RAMP_LEN);

  assert_full_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && eff_win && int'(level) == RAMP_LEN) |=> pix_out == $past(pix_in));

  assert_dark_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (pix_out == '0));

  assert_force_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && ext_sel && !ext_win) |=> !win_stat);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_start) |=> pos_q == POS_W'(1));

  assert_open_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPEN) |-> win_stat);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(pix_out) && $stable(win_stat) && $stable(level));
endmodule

bind vid_window_ramp vwr_checker #(
  .DATA_W(DATA_W), .POS_W(POS_W), .RAMP_LEN(RAMP_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_en     (pix_en),
  .line_start (line_start),
  .ext_sel    (ext_sel),
  .ext_win    (ext_win),
  .eff_win    (eff_win),
  .pix_in     (pix_in),
  .pix_out    (pix_out),
  .win_stat   (win_stat),
  .pos_q      (pos_q),
  .level      (level),
  .phase      (phase)
);

// File: tb/vid_window_ramp_test.sv
module vid_window_ramp_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 10;
  localparam int POS_W  = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pix_en = 1'b0;
  logic              line_start = 1'b0;
  logic [POS_W-1:0]  open_cnt = '0;
  logic [POS_W-1:0]  close_cnt = '0;
  logic              ext_sel = 1'b0;
  logic              ext_win = 1'b0;
  logic [DATA_W-1:0] pix_in = '0;
  logic [DATA_W-1:0] pix_out;
  logic              win_stat;

  int checks = 0;
  int errors = 0;

  int m_pos = 0, m_lvl = 0, m_held = 0, m_out = 0;
  bit m_stat = 1'b0, m_partial = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_window_ramp #(.DATA_W(DATA_W), .POS_W(POS_W), .RAMP_LEN(4)) uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
    .open_cnt(open_cnt), .close_cnt(close_cnt), .ext_sel(ext_sel),
    .ext_win(ext_win), .pix_in(pix_in), .pix_out(pix_out), .win_stat(win_stat)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, got, exp, $time);
    end
  endtask

  // One cycle; inputs applied at a falling edge, outputs compared at the next.
  task automatic step(input bit en, input bit ls, input int d,
                      input bit es, input bit ew, input string tag);
    int cur, prev;
    bit inw, eff;
    string t;
    pix_en = en; line_start = ls; pix_in = DATA_W'(d);
    ext_sel = es; ext_win = ew;
    @(posedge clk);
    @(negedge clk);
    t = tag;
    if (en) begin
      cur = ls ? 0 : m_pos;
      inw = (cur >= int'(open_cnt)) && (cur < int'(close_cnt));
      eff = inw && (!es || ew);
      prev = m_lvl;
      if (eff) begin
        m_lvl = (m_lvl < 4) ? m_lvl + 1 : 4;
        m_held = d;
        m_out = (d * m_lvl) / 4;
        if (t == "") t = (prev < 4) ? "R4" : "R3";
      end else begin
        if (prev == 4) m_partial = 1'b0;
        else if (prev > 0 && m_stat) m_partial = 1'b1;
        m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
        m_out = (m_held * m_lvl) / 4;
        if (t == "") t = (prev == 0) ? "R3" : (m_partial ? "R6" : "R5");
        if (es && !ew && inw) t = "R7";
      end
      m_stat = eff;
      m_pos = cur + 1;
    end else begin
      if (ls) m_pos = 0;
      t = "R10";
    end
    check(t, int'(pix_out), m_out);
    check("R9", int'(win_stat), int'(m_stat));
  endtask

  task automatic line(input int op, input int cl, input int len,
                      input int gap_every, input string tag);
    open_cnt = POS_W'(op); close_cnt = POS_W'(cl);
    for (int p = 0; p < len; p++) begin
      step(1'b1, p == 0, (p * 73 + op * 11 + cl * 5 + 17) & 1023, 1'b0, p[0], tag);
      if (gap_every > 0 && (p % gap_every) == gap_every - 1)
        step(1'b0, 1'b0, 999, 1'b0, 1'b0, "R10");
    end
  endtask

  initial begin
    int opens[4] = '{0, 1, 3, 6};
    int widths[6] = '{0, 1, 2, 3, 5, 9};
    repeat (3) @(negedge clk);
    check("R1", int'(pix_out), 0);
    check("R1", int'(win_stat), 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 0, 1'b0, 1'b0, "R1");

    // Sweep of window placements, widths 0..9 incl. partial ramps (R3 R4 R5 R6)
    foreach (opens[i])
      foreach (widths[j])
        line(opens[i], opens[i] + widths[j], 18, 5, "");

    // External gate: pulse low mid-window, and short high pulses (R7 R8)
    open_cnt = 11'd2; close_cnt = 11'd16;
    for (int p = 0; p < 22; p++) begin
      bit ew = !(p == 8 || p == 9 || (p >= 12 && p <= 13));
      step(1'b1, p == 0, (p * 41 + 9) & 1023, 1'b1, ew, (p >= 8 && p <= 19) ? "R8" : "");
    end
    for (int p = 0; p < 16; p++)
      step(1'b1, p == 0, (p * 29 + 300) & 1023, 1'b1, 1'b0, "R7");
    for (int p = 0; p < 16; p++)
      step(1'b1, p == 0, (p * 31 + 5) & 1023, 1'b1, (p == 4 || p == 5), "R8");

    // Mid-line restart, then a strobe on an idle cycle (R2)
    open_cnt = 11'd3; close_cnt = 11'd12;
    for (int p = 0; p < 8; p++) step(1'b1, p == 0, p * 50 + 3, 1'b0, 1'b0, "");
    for (int p = 0; p < 14; p++) step(1'b1, p == 0, p * 45 + 7, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, 0, 1'b0, 1'b0, "R2");
    for (int p = 0; p < 14; p++) step(1'b1, 1'b0, p * 33 + 1, 1'b0, 1'b0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule